// File: doc/BRIEF.md
# Bitstream Tone Correlator

This block measures how strongly a single chosen frequency is present in a one-bit oversampled stream, such as the output of a sigma-delta modulator on an input pin. An internal oscillator holds a phase accumulator that advances by a programmable frequency word on each sample strobe. The upper phase bits select sine and cosine reference values from a table. Each accepted input bit adds the reference values to a pair of running sums, or subtracts them. At the end of a run of programmed length, the sine sum and the cosine sum are the quadrature and in-phase parts of the chosen tone. The host derives magnitude and phase from them.

Software writes the frequency word, the start phase and the sample count through a small register bus. It then issues a start command. It polls a status word until the run finishes and reads the two sums. Repeating the run at a series of frequency words builds up a spectrum of the input. Partial sums can be read at any time, and an abort command ends a run early.

Top module: `tone_correlator`

## Requirements
- R1: After reset both sums read 0 and the status word reads 0 (bit 0 = finished, bit 1 = running).
- R2: Writes to address 0 (frequency word), 1 (start phase) and 2 (sample count) are stored and read back unchanged from the same addresses.
- R3: Writing address 3 with bit 0 set and bit 1 clear while not running starts a run. The start clears both sums, loads the start phase into the oscillator, clears the finished flag and loads the sample count. The same command is ignored while a run is active.
- R4: Each strobe accepted during a run uses the top 8 phase bits as table index k. The sine sum takes table entry k and the cosine sum takes entry (k+64) mod 256. An input bit of 1 adds the entry and an input bit of 0 subtracts it.
- R5: Table entry k, for k below 128, is trunc(127*16*k*(128-k) / (81920 - 4*k*(128-k))). For k of 128 or more, the entry is the negative of entry k-128.
- R6: The phase advances by the frequency word after each accepted strobe and wraps modulo 2^32. The first sample of a run uses the start phase.
- R7: After as many accepted strobes as the sample count, the status reads finished and not running, and the sums no longer change. A sample count of 0 reads finished on the cycle after the start, with both sums at 0.
- R8: A strobe while no run is active changes neither sum.
- R9: Each sum saturates at the largest or smallest value of its signed width instead of wrapping.
- R10: Writing address 3 with bit 1 set during a run ends it. Status then reads 0 and the sums keep their values. A later start is accepted.
- R11: During a run, addresses 4 (sine sum) and 5 (cosine sum) return the partial sums, sign-extended to the bus width, and the status reads running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Write address |
| cfg_wdata | input | BUS_W | Write data |
| rd_addr | input | 3 | Read address (6 = status) |
| rd_data | output | BUS_W | Read data, combinational from rd_addr |
| bit_in | input | 1 | Modulator output bit |
| bit_stb | input | 1 | Sample strobe qualifying bit_in |

## Verification
A wrong phase step or a wrong table entry shows as a wrong sum at address 4 or 5 on the cycle after the first affected strobe. It then stays wrong for the rest of the run. Mistakes in the sample counter appear at the status word as a finish that comes one strobe early or late. Because the sums freeze at the finish, such a mistake also leaves one extra or one missing term in the final sums. Saturation and abort faults are visible right after the strobe or command that triggers them, since every sum is readable combinationally.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [2:0] {
        A_FREQ  = 3'd0,
        A_PHASE = 3'd1,
        A_COUNT = 3'd2,
        A_CMD   = 3'd3,
        A_SIN   = 3'd4,
        A_COS   = 3'd5,
        A_STAT  = 3'd6
    } reg_addr_e;

    localparam int CMD_GO    = 0;
    localparam int CMD_ABORT = 1;

    // Rational sine approximation over one half period of 'half' steps.
    function automatic int sine_entry(int k, int half, int amp);
        int kk;
        int p;
        int mag;
        kk  = (k >= half) ? k - half : k;
        p   = kk * (half - kk);
        mag = (amp * 16 * p) / (5 * half * half - 4 * p);
        return (k >= half) ? -mag : mag;
    endfunction

endpackage

// File: rtl/tc_nco.sv
module tc_nco #(
    parameter int PH_W     = 32,
    parameter int TBL_BITS = 8,
    parameter int SAMP_W   = 8,
    parameter int AMP      = 127
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [PH_W-1:0]          load_val,
    input  logic                     step,
    input  logic [PH_W-1:0]          freq,
    output logic signed [SAMP_W-1:0] sin_o,
    output logic signed [SAMP_W-1:0] cos_o
);
    localparam int TBL  = 1 << TBL_BITS;
    localparam int HALF = TBL / 2;
    localparam int QTR  = TBL / 4;

    logic signed [SAMP_W-1:0] rom [TBL];

    for (genvar k = 0; k < TBL; k++) begin : g_rom
        assign rom[k] = SAMP_W'(tc_pkg::sine_entry(k, HALF, AMP));
    end

    logic [PH_W-1:0]     phase_d, phase_q;
    logic [TBL_BITS-1:0] sidx, cidx;

    always_comb begin
        phase_d = phase_q;
        if (load)      phase_d = load_val;
        else if (step) phase_d = phase_q + freq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign sidx  = phase_q[PH_W-1 -: TBL_BITS];
    assign cidx  = sidx + TBL_BITS'(QTR);
    assign sin_o = rom[sidx];
    assign cos_o = rom[cidx];
endmodule

// File: rtl/tc_sat_acc.sv
module tc_sat_acc #(
    parameter int ACC_W  = 32,
    parameter int SAMP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    input  logic                     up,
    input  logic signed [SAMP_W-1:0] val,
    output logic signed [ACC_W-1:0]  acc_o
);
    localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W-1:0] acc_d, acc_q;
    logic signed [ACC_W:0]   wide, vx, sum;

    always_comb begin
        wide  = (ACC_W+1)'(acc_q);
        vx    = (ACC_W+1)'(val);
        sum   = up ? wide + vx : wide - vx;
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (en) begin
            if (sum[ACC_W] != sum[ACC_W-1]) acc_d = sum[ACC_W] ? MINV : MAXV;
            else                            acc_d = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/tone_correlator.sv
module tone_correlator #(
    parameter int PH_W     = 32,
    parameter int TBL_BITS = 8,
    parameter int SAMP_W   = 8,
    parameter int AMP      = 127,
    parameter int ACC_W    = 32,
    parameter int CNT_W    = 32,
    parameter int BUS_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [BUS_W-1:0] cfg_wdata,
    input  logic [2:0]       rd_addr,
    output logic [BUS_W-1:0] rd_data,
    input  logic             bit_in,
    input  logic             bit_stb
);
    import tc_pkg::*;

    localparam int NCH = 2;

    typedef struct packed {
        logic [PH_W-1:0]  freq;
        logic [PH_W-1:0]  phase0;
        logic [CNT_W-1:0] count_cfg;
        logic [CNT_W-1:0] left;
        logic             busy;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic start_go, abort_go, take, cmd_wr;
    logic busy_q, done_q;
    logic [CNT_W-1:0] left_q;
    logic signed [SAMP_W-1:0] ref_v [NCH];
    logic signed [ACC_W-1:0]  acc_v [NCH];
    logic signed [ACC_W-1:0]  sin_acc, cos_acc;

    always_comb begin
        ctl_d    = ctl_q;
        cmd_wr   = cfg_we && (cfg_addr == 3'(A_CMD));
        abort_go = cmd_wr && cfg_wdata[CMD_ABORT] && ctl_q.busy;
        start_go = cmd_wr && cfg_wdata[CMD_GO] && !cfg_wdata[CMD_ABORT] && !ctl_q.busy;
        take     = ctl_q.busy && bit_stb;
        if (cfg_we && cfg_addr == 3'(A_FREQ))  ctl_d.freq      = cfg_wdata[PH_W-1:0];
        if (cfg_we && cfg_addr == 3'(A_PHASE)) ctl_d.phase0    = cfg_wdata[PH_W-1:0];
        if (cfg_we && cfg_addr == 3'(A_COUNT)) ctl_d.count_cfg = cfg_wdata[CNT_W-1:0];
        if (abort_go) begin
            ctl_d.busy = 1'b0;
        end else if (start_go) begin
            ctl_d.left = ctl_q.count_cfg;
            ctl_d.busy = (ctl_q.count_cfg != '0);
            ctl_d.done = (ctl_q.count_cfg == '0);
        end else if (take) begin
            ctl_d.left = ctl_q.left - 1'b1;
            if (ctl_q.left == CNT_W'(1)) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy_q = ctl_q.busy;
    assign done_q = ctl_q.done;
    assign left_q = ctl_q.left;

    tc_nco #(.PH_W(PH_W), .TBL_BITS(TBL_BITS), .SAMP_W(SAMP_W), .AMP(AMP)) u_nco (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_go),
        .load_val(ctl_q.phase0),
        .step    (take),
        .freq    (ctl_q.freq),
        .sin_o   (ref_v[0]),
        .cos_o   (ref_v[1])
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_acc
        tc_sat_acc #(.ACC_W(ACC_W), .SAMP_W(SAMP_W)) u_acc (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (start_go),
            .en   (take),
            .up   (bit_in),
            .val  (ref_v[ch]),
            .acc_o(acc_v[ch])
        );
    end

    assign sin_acc = acc_v[0];
    assign cos_acc = acc_v[1];

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            3'(A_FREQ):  rd_data = BUS_W'(ctl_q.freq);
            3'(A_PHASE): rd_data = BUS_W'(ctl_q.phase0);
            3'(A_COUNT): rd_data = BUS_W'(ctl_q.count_cfg);
            3'(A_SIN):   rd_data = BUS_W'(sin_acc);
            3'(A_COS):   rd_data = BUS_W'(cos_acc);
            3'(A_STAT):  rd_data = BUS_W'({ctl_q.busy, ctl_q.done});
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tc_checks.sv
module tc_checks #(
    parameter int ACC_W = 32,
    parameter int CNT_W = 32,
    parameter int AMP   = 127
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    done,
    input logic                    start_go,
    input logic                    abort_go,
    input logic                    take,
    input logic [CNT_W-1:0]        left,
    input logic signed [ACC_W-1:0] sin_acc,
    input logic signed [ACC_W-1:0] cos_acc
);
    logic signed [ACC_W-1:0] prev_sin;
    logic signed [ACC_W:0]   dsin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_sin <= '0;
        else        prev_sin <= sin_acc;
    end
    assign dsin = (ACC_W+1)'(sin_acc) - (ACC_W+1)'(prev_sin);

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> (sin_acc == '0 && cos_acc == '0 && !done == busy));

    p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && left == CNT_W'(1) && !abort_go) |=> (done && !busy));

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_go) |=> ($stable(sin_acc) && $stable(cos_acc)));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (dsin <= (ACC_W+1)'(AMP) && dsin >= -(ACC_W+1)'(AMP)));

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_go |=> (!busy && !done));
endmodule

bind tone_correlator tc_checks #(.ACC_W(ACC_W), .CNT_W(CNT_W), .AMP(AMP)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_q),
    .done    (done_q),
    .start_go(start_go),
    .abort_go(abort_go),
    .take    (take),
    .left    (left_q),
    .sin_acc (sin_acc),
    .cos_acc (cos_acc)
);

// File: tb/tone_correlator_tb.sv
`timescale 1ns/1ps
module tone_correlator_tb;
    localparam int ACC_W = 12;
    localparam int SMAX  = (1 << (ACC_W-1)) - 1;
    localparam int SMIN  = -(1 << (ACC_W-1));
    localparam int NV    = 5;

    localparam logic [31:0] V_FREQ  [NV] = '{32'h4000_0000, 32'h0100_0000, 32'h0B00_0000, 32'hF800_0000, 32'h0380_0000};
    localparam logic [31:0] V_PHASE [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h2000_0000, 32'hC000_0000, 32'h1234_5678};
    localparam int          V_CNT   [NV] = '{8, 32, 20, 16, 32};
    localparam logic [31:0] V_BITS  [NV] = '{32'h0000_00A6, 32'hFFFF_FFFF, 32'h0F0F_5A3C, 32'h0000_AAAA, 32'h9E37_79B9};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        bit_in = 1'b0;
    logic        bit_stb = 1'b0;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    tone_correlator #(.ACC_W(ACC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .bit_in(bit_in), .bit_stb(bit_stb)
    );

    function automatic int tab(int k);
        int kk, p, m;
        kk = k % 256;
        if (kk >= 128) return -tab(kk - 128);
        p = kk * (128 - kk);
        m = (127 * 16 * p) / (81920 - 4 * p);
        return m;
    endfunction

    function automatic int sat(int v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic stb(input logic b);
        @(negedge clk);
        bit_stb = 1'b1; bit_in = b;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] act;
        rd(a, act);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr %0d actual %0h expected %0h", req, a, act, exp);
        end
    endtask

    task automatic run_cfg(input logic [31:0] f, input logic [31:0] ph, input int n);
        wr(3'd0, f);
        wr(3'd1, ph);
        wr(3'd2, 32'(n));
        wr(3'd3, 32'h1);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", 3'd4, 32'h0);
        check("R1", 3'd5, 32'h0);
        check("R1", 3'd6, 32'h0);

        // R8 strobe before any run
        stb(1'b1);
        check("R8", 3'd4, 32'h0);

        // R2 readback
        wr(3'd0, 32'hDEAD_BEEF);
        wr(3'd1, 32'h1357_9BDF);
        wr(3'd2, 32'h0000_0123);
        check("R2", 3'd0, 32'hDEAD_BEEF);
        check("R2", 3'd1, 32'h1357_9BDF);
        check("R2", 3'd2, 32'h0000_0123);

        // R4 R5 R6 R7 vector table
        for (int v = 0; v < NV; v++) begin
            logic [31:0] ph;
            int es, ec;
            ph = V_PHASE[v]; es = 0; ec = 0;
            run_cfg(V_FREQ[v], V_PHASE[v], V_CNT[v]);
            for (int i = 0; i < V_CNT[v]; i++) begin
                stb(V_BITS[v][i]);
                if (V_BITS[v][i]) begin
                    es = sat(es + tab(int'(ph[31:24])));
                    ec = sat(ec + tab(int'(ph[31:24]) + 64));
                end else begin
                    es = sat(es - tab(int'(ph[31:24])));
                    ec = sat(ec - tab(int'(ph[31:24]) + 64));
                end
                ph = ph + V_FREQ[v];
            end
            check("R4_R5_R6 sine", 3'd4, 32'(es));
            check("R4_R5_R6 cosine", 3'd5, 32'(ec));
            check("R7 status", 3'd6, 32'h1);
        end

        // R11 partial sums, R3 start ignored while busy
        run_cfg(32'h0, 32'h4000_0000, 10);
        check("R3 cleared", 3'd4, 32'h0);
        for (int i = 0; i < 3; i++) stb(1'b1);
        check("R11 partial", 3'd4, 32'd381);
        check("R11 cosine", 3'd5, 32'h0);
        check("R11 busy", 3'd6, 32'h2);
        wr(3'd3, 32'h1);
        for (int i = 0; i < 7; i++) stb(1'b1);
        check("R3 ignored", 3'd4, 32'd1270);
        check("R7 finished", 3'd6, 32'h1);
        stb(1'b0);
        stb(1'b1);
        check("R7 frozen", 3'd4, 32'd1270);

        // R7 zero count
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h1);
        check("R7 zero count", 3'd6, 32'h1);
        check("R7 zero sum", 3'd4, 32'h0);

        // R9 saturation both directions
        run_cfg(32'h0, 32'h4000_0000, 20);
        for (int i = 0; i < 20; i++) stb(1'b1);
        check("R9 high", 3'd4, 32'(SMAX));
        run_cfg(32'h0, 32'h4000_0000, 20);
        for (int i = 0; i < 20; i++) stb(1'b0);
        check("R9 low", 3'd4, 32'(SMIN));

        // R10 abort
        run_cfg(32'h0, 32'h4000_0000, 10);
        for (int i = 0; i < 3; i++) stb(1'b1);
        wr(3'd3, 32'h2);
        check("R10 status", 3'd6, 32'h0);
        stb(1'b1);
        check("R10 kept", 3'd4, 32'd381);
        run_cfg(32'h0, 32'h4000_0000, 2);
        stb(1'b1);
        stb(1'b1);
        check("R10 restart", 3'd4, 32'd254);
        check("R10 restart done", 3'd6, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule